// File: doc/BRIEF.md
# General-Purpose I/O Register Block

This block is a general-purpose I/O controller for 32 pins. It sits on a simple single-cycle register port and holds three word registers: a pin-level register, a pin-direction register and a spare auxiliary word. The level register drives the pin output bus and the direction register drives the output-enable bus. Software reads the level through its own address. It raises or lowers output levels only through two dedicated write addresses, one that sets bits and one that clears them.

A set or clear write is judged as a whole word. It is applied in full only when the written mask overlaps at least one pin that is configured as an output. Otherwise nothing changes and a one-cycle reject pulse is raised. Three edge-control addresses are reserved in the map: writes to them are accepted and discarded, and reads return zero. The block provides nine interrupt lines, eight per-pin lines and one combined line, and all of them are held inactive.

Top module: `gpio_regblk`

## Requirements
- R1: After synchronous reset the level, direction and auxiliary registers are zero, so pin_out, pin_oe and every register read return 0, and wr_reject is 0.
- R2: A write to offset 0x04 loads the direction register. A read of 0x04 returns it, and pin_oe equals it from the cycle after the write.
- R3: A write to offset 0x20 loads the auxiliary register, and a read of 0x20 returns it.
- R4: A write to offset 0x08 whose data ANDed with the direction register is nonzero ORs the whole data word into the level register, including bits of input pins. A read of 0x00 returns the level register.
- R5: A write to offset 0x0C whose data ANDed with the direction register is nonzero clears in the level register every bit that is 1 in the data, including bits of input pins.
- R6: A write to 0x08 or 0x0C whose data has no bit in common with the direction register leaves the level register unchanged. wr_reject is then 1 for exactly the one cycle after the write and 0 again after that.
- R7: Writes to the edge-control offsets 0x10, 0x14 and 0x18 change no register, and reads from them return 0.
- R8: Only aligned full-word accesses are decoded. An address with bits [1:0] nonzero, with any bit above bit 5 set, or with an offset that is not listed returns 0 on read (this includes 0x08 and 0x0C) and has no effect on write.
- R9: bus_rdata is registered. It carries the addressed value in the cycle after bus_rd is 1, and it is 0 in the cycle after bus_rd is 0.
- R10: irq_pin (8 bits) and irq_any stay 0 at all times.
- R11: pin_out always equals the level register as read back at offset 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| pin_out | output | PINS | Level register, driven to the pads |
| pin_oe | output | PINS | Direction register, used as output enable |
| wr_reject | output | 1 | One-cycle pulse after a rejected set or clear write |
| irq_pin | output | IRQ_LINES | Per-pin interrupt lines, held low |
| irq_any | output | 1 | Combined interrupt line, held low |

## Verification
The bench builds the block with its default values: PINS and DATA_W of 32, and ADDR_W of 12. With a 12-bit address, an access such as 0x104 matches a valid offset in its low bits but has upper bits set, so the bench can show that those bits are decoded and that such an access does not alias onto a register. With full-width pins, a set or clear mask can overlap the output pins in a single low bit while also carrying high input-pin bits. This lets the bench tell whole-word application apart from per-bit masking, and it covers both the accept and the reject path of each operation.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;

    // Offset field width; decoded offsets fit in six bits
    localparam int OFF_W = 6;

    // Register offsets (byte addresses, word aligned)
    localparam logic [OFF_W-1:0] OFF_LEVEL = 6'h00;
    localparam logic [OFF_W-1:0] OFF_DIR   = 6'h04;
    localparam logic [OFF_W-1:0] OFF_SET   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_CLR   = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_RISE  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_FALL  = 6'h14;
    localparam logic [OFF_W-1:0] OFF_ESTAT = 6'h18;
    localparam logic [OFF_W-1:0] OFF_AUX   = 6'h20;

    // One select bit per decoded register slot
    typedef struct packed {
        logic level;
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic estat;
        logic aux;
    } reg_sel_t;

    // Operation applied to the level register in a cycle
    typedef enum logic [1:0] {
        LOP_IDLE = 2'd0,
        LOP_SET  = 2'd1,
        LOP_CLR  = 2'd2
    } lvl_op_e;

    function automatic logic word_aligned(input logic [1:0] low_bits);
        return low_bits == 2'b00;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regblk_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    logic             upper_clear;
    logic [OFF_W-1:0] off;

    assign off = addr[OFF_W-1:0];

    generate
        if (ADDR_W > OFF_W) begin : g_upper
            assign upper_clear = ~|addr[ADDR_W-1:OFF_W];
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = '0;
        if (upper_clear && word_aligned(addr[1:0])) begin
            case (off)
                OFF_LEVEL: sel.level = 1'b1;
                OFF_DIR:   sel.dir   = 1'b1;
                OFF_SET:   sel.set   = 1'b1;
                OFF_CLR:   sel.clr   = 1'b1;
                OFF_RISE:  sel.rise  = 1'b1;
                OFF_FALL:  sel.fall  = 1'b1;
                OFF_ESTAT: sel.estat = 1'b1;
                OFF_AUX:   sel.aux   = 1'b1;
                default:   sel       = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_word_reg.sv
module gpio_word_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end

    // R1: the register is zero in the cycle after reset
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/gpio_level_ctrl.sv
module gpio_level_ctrl
    import gpio_regblk_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  lvl_op_e         op,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] dir,
    output logic [PINS-1:0] level,
    output logic            reject
);

    logic touches_output;
    logic is_op;

    assign touches_output = |(mask & dir);
    assign is_op          = (op != LOP_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= '0;
            reject <= 1'b0;
        end else begin
            reject <= is_op && !touches_output;
            if (touches_output) begin
                case (op)
                    LOP_SET: level <= level | mask;
                    LOP_CLR: level <= level & ~mask;
                    default: level <= level;
                endcase
            end
        end
    end

    // R4: accepted set applies the full word
    p_set_full_word_r4: assert property (@(posedge clk) disable iff (rst)
        (op == LOP_SET && touches_output) |=> (level == ($past(level) | $past(mask))));

    // R5: accepted clear removes every masked bit
    p_clr_full_word_r5: assert property (@(posedge clk) disable iff (rst)
        (op == LOP_CLR && touches_output) |=> (level == ($past(level) & ~$past(mask))));

    // R6: rejected operation keeps the level and pulses reject
    p_reject_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (is_op && !touches_output) |=> ($stable(level) && reject));

    // R6: no operation means no change and no reject pulse
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !is_op |=> ($stable(level) && !reject));

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port #(
    parameter int PINS   = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              pick_level,
    input  logic              pick_dir,
    input  logic              pick_aux,
    input  logic [PINS-1:0]   level,
    input  logic [PINS-1:0]   dir,
    input  logic [DATA_W-1:0] aux,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mux_val;

    always_comb begin
        mux_val = '0;
        if (pick_level)    mux_val = DATA_W'(level);
        else if (pick_dir) mux_val = DATA_W'(dir);
        else if (pick_aux) mux_val = aux;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= mux_val;
        else         rdata <= '0;
    end

    // R9: no read strobe gives zero data in the next cycle
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (rdata == '0));

    // R8: a read that selects no register returns zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd && !pick_level && !pick_dir && !pick_aux) |=> (rdata == '0));

endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
    import gpio_regblk_pkg::*;
#(
    parameter int PINS      = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12,
    parameter int IRQ_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [PINS-1:0]      pin_out,
    output logic [PINS-1:0]      pin_oe,
    output logic                 wr_reject,
    output logic [IRQ_LINES-1:0] irq_pin,
    output logic                 irq_any
);

    reg_sel_t          sel;
    lvl_op_e           lvl_op;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   level_q;
    logic [DATA_W-1:0] aux_q;
    logic              edge_hit;
    logic              misaligned;

    gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        lvl_op = LOP_IDLE;
        if (bus_wr && sel.set)      lvl_op = LOP_SET;
        else if (bus_wr && sel.clr) lvl_op = LOP_CLR;
    end

    gpio_word_reg #(.W(PINS)) u_dir (
        .clk (clk),
        .rst (rst),
        .we  (bus_wr && sel.dir),
        .d   (bus_wdata[PINS-1:0]),
        .q   (dir_q)
    );

    gpio_word_reg #(.W(DATA_W)) u_aux (
        .clk (clk),
        .rst (rst),
        .we  (bus_wr && sel.aux),
        .d   (bus_wdata),
        .q   (aux_q)
    );

    gpio_level_ctrl #(.PINS(PINS)) u_level (
        .clk    (clk),
        .rst    (rst),
        .op     (lvl_op),
        .mask   (bus_wdata[PINS-1:0]),
        .dir    (dir_q),
        .level  (level_q),
        .reject (wr_reject)
    );

    gpio_read_port #(.PINS(PINS), .DATA_W(DATA_W)) u_read (
        .clk        (clk),
        .rst        (rst),
        .rd         (bus_rd),
        .pick_level (sel.level),
        .pick_dir   (sel.dir),
        .pick_aux   (sel.aux),
        .level      (level_q),
        .dir        (dir_q),
        .aux        (aux_q),
        .rdata      (bus_rdata)
    );

    assign pin_out = level_q;
    assign pin_oe  = dir_q;
    assign irq_pin = '0;
    assign irq_any = 1'b0;

    assign edge_hit   = sel.rise | sel.fall | sel.estat;
    assign misaligned = !word_aligned(bus_addr[1:0]);

    // R2: direction write shows on pin_oe next cycle
    p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel.dir) |=> (pin_oe == $past(bus_wdata[PINS-1:0])));

    // R3: auxiliary write is held
    p_aux_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel.aux) |=> (aux_q == $past(bus_wdata)));

    // R7: edge-control writes leave every register alone
    p_edge_noeffect_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && edge_hit) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(aux_q) && !wr_reject));

    // R8: misaligned writes leave every register alone
    p_misaligned_write_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && misaligned) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(aux_q)));

    // R8: misaligned reads return zero
    p_misaligned_read_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && misaligned) |=> (bus_rdata == '0));

endmodule

// File: tb/gpio_regblk_bench.sv
module gpio_regblk_bench;

    localparam int PINS   = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int IRQS   = 8;

    typedef struct {
        logic [31:0] val;
        string       req;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [PINS-1:0]   pin_out;
    logic [PINS-1:0]   pin_oe;
    logic              wr_reject;
    logic [IRQS-1:0]   irq_pin;
    logic              irq_any;

    int total = 0;
    int bad   = 0;

    exp_item_t exp_q[$];
    logic      rd_pending = 1'b0;

    // model state from the requirements
    logic [31:0] m_level = '0;
    logic [31:0] m_dir   = '0;
    logic [31:0] m_aux   = '0;

    always #10 clk = ~clk;

    gpio_regblk #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_LINES(IRQS)) u_gpio_regblk (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .wr_reject (wr_reject),
        .irq_pin   (irq_pin),
        .irq_any   (irq_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00 || a[ADDR_W-1:6] != '0) return 32'h0;
        case (a[5:0])
            6'h00:   return m_level;
            6'h04:   return m_dir;
            6'h20:   return m_aux;
            default: return 32'h0;
        endcase
    endfunction

    // monitor: compare registered read data with the scoreboard
    always @(posedge clk) rd_pending <= bus_rd && !rst;

    always @(negedge clk) begin
        if (rd_pending) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 actual=%h expected=<no read queued>", bus_rdata);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.req, bus_rdata, it.val);
            end
        end
    end

    task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
        exp_item_t it;
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        it.val   = model_read(a);
        it.req   = req;
        exp_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
        logic rej;
        rej = 1'b0;
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        if (a[1:0] == 2'b00 && a[ADDR_W-1:6] == '0) begin
            case (a[5:0])
                6'h04: m_dir = d;
                6'h08: if ((d & m_dir) != 0) m_level = m_level | d; else rej = 1'b1;
                6'h0C: if ((d & m_dir) != 0) m_level = m_level & ~d; else rej = 1'b1;
                6'h20: m_aux = d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0;
        check({req, " wr_reject pulse R6"}, {31'b0, wr_reject}, {31'b0, rej});
        check({req, " pin_out R11"}, pin_out, m_level);
        check({req, " pin_oe R2"}, pin_oe, m_dir);
        @(negedge clk);
        check({req, " wr_reject drop R6"}, {31'b0, wr_reject}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 wr_reject", {31'b0, wr_reject}, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        do_read(12'h000, "R1 level");
        do_read(12'h004, "R1 dir");
        do_read(12'h020, "R1 aux");

        // R6 set with no outputs configured
        do_write(12'h008, 32'hFFFF_FFFF, "R6 set all-input");
        do_read(12'h000, "R6 level unchanged");

        // R2 direction
        do_write(12'h004, 32'h0000_00FF, "R2 dir");
        do_read(12'h004, "R2 dir readback");

        // R4 set, overlap in one bit, high input bits applied too
        do_write(12'h008, 32'hF000_0001, "R4 set");
        do_read(12'h000, "R4 level");
        do_write(12'h008, 32'h0000_0F00, "R6 set no overlap");
        do_read(12'h000, "R6 level after rejected set");

        // R5 clear: rejected then accepted
        do_write(12'h00C, 32'hF000_0000, "R6 clr no overlap");
        do_write(12'h00C, 32'h1000_0003, "R5 clr");
        do_read(12'h000, "R5 level");

        // R3 auxiliary
        do_write(12'h020, 32'hDEAD_BEEF, "R3 aux");
        do_read(12'h020, "R3 aux readback");

        // R7 edge-control offsets
        do_write(12'h010, 32'hFFFF_FFFF, "R7 rise");
        do_write(12'h014, 32'hFFFF_FFFF, "R7 fall");
        do_write(12'h018, 32'hFFFF_FFFF, "R7 estat");
        do_read(12'h010, "R7 rise read");
        do_read(12'h014, "R7 fall read");
        do_read(12'h018, "R7 estat read");
        do_read(12'h000, "R7 level kept");
        do_read(12'h020, "R7 aux kept");

        // R8 unmapped, misaligned, upper-bit addresses
        do_read(12'h008, "R8 set read");
        do_read(12'h00C, "R8 clr read");
        do_read(12'h024, "R8 0x24 read");
        do_read(12'h005, "R8 misaligned read");
        do_read(12'h104, "R8 upper-bit read");
        do_write(12'h005, 32'h1234_5678, "R8 misaligned dir write");
        do_write(12'h104, 32'h0F0F_0F0F, "R8 upper-bit dir write");
        do_write(12'h108, 32'hFFFF_FFFF, "R8 upper-bit set write");
        do_write(12'h03C, 32'hFFFF_FFFF, "R8 unmapped write");
        do_read(12'h004, "R8 dir kept");
        do_read(12'h000, "R8 level kept");

        // R9 zero after an idle cycle
        do_read(12'h020, "R9 aux read");
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);

        // R4/R5 again with a wider direction
        do_write(12'h004, 32'hFFFF_0000, "R2 dir wide");
        do_write(12'h008, 32'h0001_00F0, "R4 set wide");
        do_write(12'h00C, 32'h0000_00FF, "R6 clr low-only");
        do_write(12'h00C, 32'hFFFF_FFFF, "R5 clr all");
        do_read(12'h000, "R5 level zero");

        // R10 interrupts
        check("R10 irq_pin", {24'b0, irq_pin}, 32'h0);
        check("R10 irq_any", {31'b0, irq_any}, 32'h0);

        repeat (2) @(negedge clk);
        check("R9 scoreboard drained", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // R10 checked continuously
    always @(negedge clk) begin
        if (!rst && (irq_pin != '0 || irq_any)) begin
            total++; bad++;
            $display("FAIL R10 actual=%h expected=0", {irq_any, irq_pin});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule